// File: doc/BRIEF.md
# Sequential Operand-Register ALU

This block wraps a small arithmetic unit in registers. Both operands arrive one after the other on a single shared data input. A load strobe, together with a select bit, writes the input byte into operand register A or operand register B. A separate run strobe evaluates the operation picked by a 4-bit opcode on the stored operands. On that same edge it latches the low result byte X, the high result byte Y and a set of status flags.

The result byte that appears on the output is chosen by an output select bit. The stored results and flags hold until the next run strobe, so operands and the opcode can be prepared for the next operation without disturbing what the output shows. The operation set is deliberately small: unsigned add, signed add, unsigned subtract, and signed and unsigned multiply. The data width is a parameter with a default of 8.

Top module: `opreg_alu`

## Requirements
- R1: While `rst` is high at a rising edge, all registers clear: the operands, both result bytes and every flag go to 0, so `res` reads 0 for either value of `sel_out`.
- R2: At a rising edge with `load` high, `din` is written into A when `sel_in` is 0 and into B when `sel_in` is 1. The other operand register keeps its value, and neither operand changes while `load` is low.
- R3: The result bytes and flags change only at a rising edge with `run` high. Changing `op`, A or B without `run` leaves `res` and every flag unchanged.
- R4: `res` shows the stored X byte when `sel_out` is 0 and the stored Y byte when `sel_out` is 1.
- R5: Opcode 0 (unsigned add) gives X = low W bits of A+B, Y = 0, and `carry` = carry out of bit W-1. `ovf` is 0.
- R6: Opcode 1 (signed add) gives X = A+B modulo 2^W, Y = 0, and `carry` = 0. `ovf` is 1 when the two's-complement sum falls outside the signed W-bit range.
- R7: Opcode 2 (unsigned subtract) gives X = A-B modulo 2^W, Y = 0, and `carry` = 1 as a borrow when A < B. `ovf` is 0.
- R8: Opcode 3 (signed multiply) puts the 2W-bit two's-complement product into {Y,X}, with `carry` = 0. `ovf` is 1 when the product does not fit in W signed bits.
- R9: Opcode 4 (unsigned multiply) puts the 2W-bit product into {Y,X}, with `carry` = 0 and `ovf` = 1 when Y is nonzero.
- R10: Opcodes 5 to 15 store X = 0 and Y = 0, with `carry` = 0 and `ovf` = 0 (so `zero` = 1).
- R11: The flags are computed from the result and latched with it:
  - `zero` = 1 when {Y,X} is all zero.
  - `neg` = bit W-1 of X.
  - `x_pal` = 1 when X reads the same with its bit order reversed.
  - `x_prime` = 1 when X, taken as unsigned, is prime.
  - `any_flag` = `zero` OR `carry` OR `ovf`.
- R12: When `load` and `run` are high in the same cycle, the run computes with the operand values held before that edge's load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Operand byte to load |
| load | input | 1 | Load strobe, one cycle |
| sel_in | input | 1 | Load target: 0 = A, 1 = B |
| op | input | 4 | Operation select |
| run | input | 1 | Evaluate and latch strobe, one cycle |
| sel_out | input | 1 | Output select: 0 = X, 1 = Y |
| res | output | W | Selected result byte |
| zero | output | 1 | Result {Y,X} is zero |
| carry | output | 1 | Carry out (add) or borrow (subtract) |
| ovf | output | 1 | Overflow |
| any_flag | output | 1 | OR of zero, carry and ovf |
| x_pal | output | 1 | X is a bit palindrome |
| x_prime | output | 1 | X is prime |
| neg | output | 1 | Most significant bit of X |

## Verification
The bench builds the block with W = 4. This makes every operand pair, 256 per opcode, cheap enough to sweep through all five arithmetic opcodes. At that width every carry, borrow, signed-overflow and product-overflow boundary is exercised, along with every palindromic and prime value of X. Samples of the unused opcodes, the hold behaviour without a run, the combined load-and-run cycle and a mid-stream reset are driven on the same build.

// File: rtl/opreg_alu.sv
`timescale 1ns/1ps
module opreg_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         load,
  input  logic         sel_in,
  input  logic [3:0]   op,
  input  logic         run,
  input  logic         sel_out,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         carry,
  output logic         ovf,
  output logic         any_flag,
  output logic         x_pal,
  output logic         x_prime,
  output logic         neg
);
  localparam int PW = 2 * W;
  localparam int DMAX = 1 << ((W + 1) / 2);

  logic [W-1:0] a_q, b_q, x_q, y_q;
  logic         z_q, c_q, v_q, pal_q, pr_q, n_q;

  logic [W:0]    sum_u, dif_u;
  logic [PW-1:0] prod_s, prod_u;
  logic [W-1:0]  x_d, y_d;
  logic          c_d, v_d;

  function automatic logic is_pal(input logic [W-1:0] v);
    logic p;
    p = 1'b1;
    for (int i = 0; i < W; i++) if (v[i] != v[W-1-i]) p = 1'b0;
    return p;
  endfunction

  function automatic logic is_prime(input logic [W-1:0] v);
    logic p;
    int   n;
    n = int'(v);
    p = (n >= 2);
    for (int d = 2; d <= DMAX; d++) if (d * d <= n && n % d == 0) p = 1'b0;
    return p;
  endfunction

  assign sum_u  = {1'b0, a_q} + {1'b0, b_q};
  assign dif_u  = {1'b0, a_q} - {1'b0, b_q};
  assign prod_s = $signed({{W{a_q[W-1]}}, a_q}) * $signed({{W{b_q[W-1]}}, b_q});
  assign prod_u = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};

  always_comb begin
    x_d = '0;
    y_d = '0;
    c_d = 1'b0;
    v_d = 1'b0;
    case (op)
      4'd0: begin x_d = sum_u[W-1:0]; c_d = sum_u[W]; end
      4'd1: begin
        x_d = sum_u[W-1:0];
        v_d = (a_q[W-1] == b_q[W-1]) && (sum_u[W-1] != a_q[W-1]);
      end
      4'd2: begin x_d = dif_u[W-1:0]; c_d = dif_u[W]; end
      4'd3: begin
        {y_d, x_d} = prod_s;
        v_d = prod_s[PW-1:W] != {W{prod_s[W-1]}};
      end
      4'd4: begin
        {y_d, x_d} = prod_u;
        v_d = |prod_u[PW-1:W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      if (sel_in) b_q <= din;
      else        a_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0;
      z_q <= 1'b0; c_q <= 1'b0; v_q <= 1'b0;
      pal_q <= 1'b0; pr_q <= 1'b0; n_q <= 1'b0;
    end else if (run) begin
      x_q   <= x_d;
      y_q   <= y_d;
      z_q   <= ~|{y_d, x_d};
      c_q   <= c_d;
      v_q   <= v_d;
      pal_q <= is_pal(x_d);
      pr_q  <= is_prime(x_d);
      n_q   <= x_d[W-1];
    end
  end

  assign res      = sel_out ? y_q : x_q;
  assign zero     = z_q;
  assign carry    = c_q;
  assign ovf      = v_q;
  assign any_flag = z_q | c_q | v_q;
  assign x_pal    = pal_q;
  assign x_prime  = pr_q;
  assign neg      = n_q;
endmodule

// File: rtl/opreg_alu_chk.sv
`timescale 1ns/1ps
module opreg_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         sel_in,
  input logic         run,
  input logic [W-1:0] din,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [W-1:0] x_q,
  input logic [W-1:0] y_q,
  input logic [5:0]   flg
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && x_q == '0 && y_q == '0 && flg == '0));

  assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_in) |=> (a_q == $past(din) && $stable(b_q)));

  assert_load_b_R2: assert property (@(posedge clk) disable iff (rst)
    (load && sel_in) |=> (b_q == $past(din) && $stable(a_q)));

  assert_operands_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(a_q) && $stable(b_q)));

  assert_results_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(x_q) && $stable(y_q) && $stable(flg)));
endmodule

bind opreg_alu opreg_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .sel_in(sel_in), .run(run), .din(din),
  .a_q(a_q), .b_q(b_q), .x_q(x_q), .y_q(y_q),
  .flg({z_q, c_q, v_q, pal_q, pr_q, n_q})
);

// File: tb/opreg_alu_tb.sv
`timescale 1ns/1ps
module opreg_alu_tb;
  localparam int W = 4;
  localparam int EW = 2 * W + 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] din = '0;
  logic load = 1'b0, sel_in = 1'b0, run = 1'b0, sel_out = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] res;
  logic zero, carry, ovf, any_flag, x_pal, x_prime, neg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  opreg_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .din(din), .load(load), .sel_in(sel_in), .op(op),
    .run(run), .sel_out(sel_out), .res(res), .zero(zero), .carry(carry),
    .ovf(ovf), .any_flag(any_flag), .x_pal(x_pal), .x_prime(x_prime), .neg(neg)
  );

  // expected packing: {X, Y, zero, carry, ovf, any, pal, prime, neg}
  function automatic logic [EW-1:0] model(input int o, input int a, input int b);
    int sa, sb, s, x, y, c, v, p, prm, pal;
    logic [2*W-1:0] pp;
    sa = (a >= (1 << (W-1))) ? a - (1 << W) : a;
    sb = (b >= (1 << (W-1))) ? b - (1 << W) : b;
    x = 0; y = 0; c = 0; v = 0;
    case (o)
      0: begin s = a + b; x = s % (1 << W); c = (s >= (1 << W)) ? 1 : 0; end
      1: begin s = sa + sb; x = (a + b) % (1 << W);
               v = (s > (1 << (W-1)) - 1 || s < -(1 << (W-1))) ? 1 : 0; end
      2: begin x = (a - b + (1 << W)) % (1 << W); c = (a < b) ? 1 : 0; end
      3: begin p = sa * sb; pp = p[2*W-1:0]; x = int'(pp[W-1:0]); y = int'(pp[2*W-1:W]);
               v = (p > (1 << (W-1)) - 1 || p < -(1 << (W-1))) ? 1 : 0; end
      4: begin p = a * b; x = p % (1 << W); y = p / (1 << W); v = (y != 0) ? 1 : 0; end
      default: ;
    endcase
    prm = (x >= 2) ? 1 : 0;
    for (int d = 2; d < x; d++) if (x % d == 0) prm = 0;
    pal = 1;
    for (int i = 0; i < W; i++) if (((x >> i) & 1) != ((x >> (W-1-i)) & 1)) pal = 0;
    model = {x[W-1:0], y[W-1:0], (x == 0 && y == 0), c[0], v[0],
             ((x == 0 && y == 0) || c != 0 || v != 0), pal[0], prm[0], x[W-1]};
  endfunction

  task automatic check(input string tag, input logic [EW-1:0] got, input logic [EW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic observe(output logic [EW-1:0] got);
    logic [W-1:0] xv, yv;
    sel_out = 1'b0; #1 xv = res;
    sel_out = 1'b1; #1 yv = res;
    got = {xv, yv, zero, carry, ovf, any_flag, x_pal, x_prime, neg};
  endtask

  task automatic cyc(input logic ld, input logic si, input logic [W-1:0] d, input logic rn);
    @(negedge clk);
    load = ld; sel_in = si; din = d; run = rn;
    @(negedge clk);
    load = 1'b0; run = 1'b0;
  endtask

  task automatic do_case(input int o, input int a, input int b, input string tag);
    logic [EW-1:0] got;
    cyc(1'b1, 1'b0, a[W-1:0], 1'b0);
    cyc(1'b1, 1'b1, b[W-1:0], 1'b0);
    op = o[3:0];
    cyc(1'b0, 1'b0, '0, 1'b1);
    observe(got);
    check(tag, got, model(o, a, b));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [EW-1:0] got, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    observe(got);
    check("R1 reset state", got, '0);

    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++) begin
        do_case(0, a, b, "R5/R11/R4 unsigned add");
        do_case(1, a, b, "R6/R11/R4 signed add");
        do_case(2, a, b, "R7/R11/R4 unsigned subtract");
        do_case(3, a, b, "R8/R11/R4 signed multiply");
        do_case(4, a, b, "R9/R11/R4 unsigned multiply");
      end

    for (int o = 5; o < 16; o++) begin
      do_case(o, 7, 3, "R10 unused opcode");
      do_case(o, 15, 15, "R10 unused opcode");
    end

    // R3: result holds while operands and opcode change without run
    do_case(4, 3, 5, "R9 setup product");
    observe(held);
    cyc(1'b1, 1'b0, 4'd9, 1'b0);
    op = 4'd0;
    cyc(1'b1, 1'b1, 4'd2, 1'b0);
    observe(got);
    check("R3 hold without run", got, held);
    cyc(1'b0, 1'b0, '0, 1'b1);
    observe(got);
    check("R3 run picks up new operands", got, model(0, 9, 2));

    // R2: loading B alone leaves A intact
    cyc(1'b1, 1'b1, 4'd6, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b1);
    observe(got);
    check("R2 B load keeps A", got, model(0, 9, 6));

    // R12: load and run together use the old A
    op = 4'd2;
    cyc(1'b1, 1'b0, 4'd1, 1'b1);
    observe(got);
    check("R12 load with run uses prior A", got, model(2, 9, 6));
    cyc(1'b0, 1'b0, '0, 1'b1);
    observe(got);
    check("R12 next run uses new A", got, model(2, 1, 6));

    // R1: reset after activity clears operands and results
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    observe(got);
    check("R1 reset clears results", got, '0);
    op = 4'd0;
    cyc(1'b0, 1'b0, '0, 1'b1);
    observe(got);
    check("R1 reset clears operands", got, model(0, 0, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule